// File: doc/BRIEF.md
# GPIO Register Block

A 32-bit general-purpose I/O controller reached through a simple single-cycle register bus. Software programs a direction word that says which pins drive, and changes driven levels through separate set and clear strobe addresses rather than by writing the level word directly. The level word drives the pad outputs and the direction word drives the pad output enables. A spare read/write word is provided for software use.

A set or clear strobe is accepted only when at least one written bit lands on a pin currently marked as output. An accepted strobe applies every written bit, and a refused strobe leaves the levels alone and flags an error. Three edge-control addresses are accepted for writes and do nothing. The nine interrupt lines are present but never assert. Each request gets a registered response one cycle later. The response carries read data and a one-cycle error flag for illegal accesses.

Top module: `gpio_regblock`

## Requirements
- R1: After reset the level, direction and spare words are zero, so `gpio_out_o`, `gpio_oe_o`, `rsp_rdata_o` and `rsp_err_o` are all zero.
- R2: A write to byte offset 0x04 loads the direction word. A read of 0x04 returns it, and `gpio_oe_o` always equals it.
- R3: A write to offset 0x08 whose data shares at least one set bit with the direction word ORs all of the written bits into the level word. `gpio_out_o` always equals the level word, and a read of offset 0x00 returns it.
- R4: A write to offset 0x0C whose data shares at least one set bit with the direction word clears all of the written bits from the level word.
- R5: A write to 0x08 or 0x0C whose data has no set bit in common with the direction word leaves the level word unchanged and raises the error flag.
- R6: Offset 0x20 holds a spare word that is written and read back unchanged and resets to zero.
- R7: Writes to offsets 0x10, 0x14 and 0x18 change no state and raise no error. Reads of these offsets return zero and raise the error flag.
- R8: A read of any offset other than 0x00, 0x04 or 0x20 returns zero and raises the error flag. A write to 0x00, to an unlisted offset, or to a misaligned address (low two address bits nonzero) raises the error flag and changes no state.
- R9: Read data and the error flag appear in the cycle after the request. The error flag is high for exactly one cycle per illegal request and never without a request. Read data is zero in a cycle that does not follow a read.
- R10: All nine interrupt outputs stay low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte address of the word |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, one cycle after a read |
| rsp_err_o | output | 1 | One-cycle illegal-access flag |
| gpio_out_o | output | 32 | Pad output values |
| gpio_oe_o | output | 32 | Pad output enables |
| irq_o | output | 9 | Interrupt lines, held low |

## Verification
The assertions assume the bus is synchronous to `clk_i`. They also assume every request is a full 32-bit word access, because the bus has no byte-enable lane. The stimulus drives inputs only between clock edges and issues no more than one request per cycle. Its addresses include the mapped words, the placeholder words, misaligned addresses and offsets beyond the map. Direction patterns are chosen so that strobes both overlap and miss the output pins.

// File: rtl/gpio_reg_pkg.sv
package gpio_reg_pkg;

  typedef enum logic [2:0] {
    SLOT_LEVEL,
    SLOT_DIR,
    SLOT_SET,
    SLOT_CLR,
    SLOT_EDGE,
    SLOT_SPARE,
    SLOT_NONE
  } slot_e;

  localparam int unsigned OFS_LEVEL = 32'h00;
  localparam int unsigned OFS_DIR   = 32'h04;
  localparam int unsigned OFS_SET   = 32'h08;
  localparam int unsigned OFS_CLR   = 32'h0C;
  localparam int unsigned OFS_SPARE = 32'h20;

  localparam int unsigned N_EDGE_SLOTS = 3;
  localparam int unsigned EDGE_BASE    = 32'h10;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output slot_e             slot_o
);

  logic [N_EDGE_SLOTS-1:0] edge_hit;

  // placeholder edge-control words sit at consecutive word offsets
  for (genvar g = 0; g < N_EDGE_SLOTS; g++) begin : g_edge
    assign edge_hit[g] = (addr_i == ADDR_W'(EDGE_BASE + 4 * g));
  end

  always_comb begin
    slot_o = SLOT_NONE;
    if      (addr_i == ADDR_W'(OFS_LEVEL)) slot_o = SLOT_LEVEL;
    else if (addr_i == ADDR_W'(OFS_DIR))   slot_o = SLOT_DIR;
    else if (addr_i == ADDR_W'(OFS_SET))   slot_o = SLOT_SET;
    else if (addr_i == ADDR_W'(OFS_CLR))   slot_o = SLOT_CLR;
    else if (addr_i == ADDR_W'(OFS_SPARE)) slot_o = SLOT_SPARE;
    else if (|edge_hit)                    slot_o = SLOT_EDGE;
  end

endmodule

// File: rtl/gpio_level_reg.sv
module gpio_level_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dir_i,
  output logic [DATA_W-1:0] level_o,
  output logic              reject_o
);

  logic              hit;
  logic [DATA_W-1:0] level_q;

  // strobe qualified as a whole: any written bit on an output pin
  assign hit      = |(wdata_i & dir_i);
  assign reject_o = (set_i | clr_i) & ~hit;
  assign level_o  = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             level_q <= '0;
    else if (set_i && hit)   level_q <= level_q | wdata_i;
    else if (clr_i && hit)   level_q <= level_q & ~wdata_i;
  end

  AST_SET_APPLIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && hit) |=> ((level_q & $past(wdata_i)) == $past(wdata_i))); // R3
  AST_CLR_APPLIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit) |=> ((level_q & $past(wdata_i)) == '0)); // R4
  AST_REJECT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |=> $stable(level_q)); // R5

endmodule

// File: rtl/gpio_rsp_reg.sv
module gpio_rsp_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              err_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= rdata_i;
      err_o   <= err_i;
    end
  end

endmodule

// File: rtl/gpio_regblock.sv
module gpio_regblock
  import gpio_reg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IRQ_N  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] gpio_out_o,
  output logic [DATA_W-1:0] gpio_oe_o,
  output logic [IRQ_N-1:0]  irq_o
);

  slot_e             slot;
  logic              rd, wr;
  logic [DATA_W-1:0] dir_q, spare_q, level;
  logic              reject;
  logic              rd_bad, wr_bad, err_d;
  logic [DATA_W-1:0] rdata_d;

  assign rd = req_valid_i & ~req_we_i;
  assign wr = req_valid_i &  req_we_i;

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (req_addr_i),
    .slot_o (slot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      spare_q <= '0;
    end else if (wr) begin
      if (slot == SLOT_DIR)   dir_q   <= req_wdata_i;
      if (slot == SLOT_SPARE) spare_q <= req_wdata_i;
    end
  end

  gpio_level_reg #(.DATA_W(DATA_W)) u_level (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (wr && slot == SLOT_SET),
    .clr_i    (wr && slot == SLOT_CLR),
    .wdata_i  (req_wdata_i),
    .dir_i    (dir_q),
    .level_o  (level),
    .reject_o (reject)
  );

  always_comb begin
    rdata_d = '0;
    rd_bad  = 1'b0;
    if (rd) begin
      unique case (slot)
        SLOT_LEVEL: rdata_d = level;
        SLOT_DIR:   rdata_d = dir_q;
        SLOT_SPARE: rdata_d = spare_q;
        default:    rd_bad  = 1'b1;
      endcase
    end
  end

  assign wr_bad = wr & (slot == SLOT_NONE || slot == SLOT_LEVEL);
  assign err_d  = rd_bad | wr_bad | reject;

  gpio_rsp_reg #(.DATA_W(DATA_W)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rdata_i (rdata_d),
    .err_i   (err_d),
    .rdata_o (rsp_rdata_o),
    .err_o   (rsp_err_o)
  );

  assign gpio_out_o = level;
  assign gpio_oe_o  = dir_q;

  // edge detection not implemented: lines held inactive
  for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
    assign irq_o[g] = 1'b0;
  end

  AST_DIR_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && slot == SLOT_DIR) |=> $stable(gpio_oe_o)); // R2
  AST_SPARE_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && slot == SLOT_SPARE) |=> $stable(spare_q)); // R6
  AST_EDGE_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && slot == SLOT_EDGE) |=> (!rsp_err_o && $stable(gpio_out_o) && $stable(gpio_oe_o))); // R7
  AST_BAD_WRITE_NO_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && slot == SLOT_NONE) |=> (rsp_err_o && $stable(gpio_out_o) && $stable(gpio_oe_o))); // R8
  AST_ERR_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> $past(req_valid_i)); // R9
  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> (rsp_rdata_o == '0)); // R9

endmodule

// File: tb/gpio_regblock_tb_top.sv
`timescale 1ns/1ps
module gpio_regblock_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pout, poe;
  logic        err;
  logic [8:0]  irq;

  int vectors = 0;
  int miss = 0;

  // reference state
  logic [31:0] m_lvl = '0, m_dir = '0, m_gp = '0;
  logic [31:0] e_rdata = '0;
  logic        e_err = 1'b0;

  always #2 clk = ~clk;

  gpio_regblock dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (valid),
    .req_we_i    (we),
    .req_addr_i  (addr),
    .req_wdata_i (wdata),
    .rsp_rdata_o (rdata),
    .rsp_err_o   (err),
    .gpio_out_o  (pout),
    .gpio_oe_o   (poe),
    .irq_o       (irq)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    vectors++;
    chk(tag, "rdata", rdata, e_rdata);
    chk(tag, "err", {31'd0, err}, {31'd0, e_err});
    chk("R3", "gpio_out", pout, m_lvl);
    chk("R2", "gpio_oe", poe, m_dir);
    chk("R10", "irq", {23'd0, irq}, 32'd0);
  endtask

  // model one bus cycle and compare after the edge
  task automatic step(bit v, bit w, logic [7:0] a, logic [31:0] d, string tag);
    logic [31:0] nr;
    logic        ne;
    valid = v; we = w; addr = a; wdata = d;
    nr = '0; ne = 1'b0;
    if (v && !w) begin
      case (a)
        8'h00:   nr = m_lvl;
        8'h04:   nr = m_dir;
        8'h20:   nr = m_gp;
        default: ne = 1'b1;
      endcase
    end else if (v && w) begin
      case (a)
        8'h04: m_dir = d;
        8'h20: m_gp = d;
        8'h08: if ((d & m_dir) != 0) m_lvl = m_lvl | d; else ne = 1'b1;
        8'h0C: if ((d & m_dir) != 0) m_lvl = m_lvl & ~d; else ne = 1'b1;
        8'h10, 8'h14, 8'h18: ;
        default: ne = 1'b1;
      endcase
    end
    @(posedge clk);
    e_rdata = nr; e_err = ne;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
    step(1'b1, 1'b1, a, d, tag);
  endtask
  task automatic rd(logic [7:0] a, string tag);
    step(1'b1, 1'b0, a, 32'h0, tag);
  endtask
  task automatic idle(string tag);
    step(1'b0, 1'b0, 8'h00, 32'h0, tag);
  endtask

  initial begin
    #1000000;
    miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h20, "R6");

    wr(8'h04, 32'h0000_00FF, "R2");
    rd(8'h04, "R2");
    wr(8'h08, 32'h0000_0103, "R3");   // bit 8 is an input pin but is still applied
    rd(8'h00, "R3");
    wr(8'h0C, 32'h0000_0001, "R4");
    rd(8'h00, "R4");
    wr(8'h08, 32'h0000_0F00, "R5");   // no overlap with direction
    wr(8'h0C, 32'h0000_0100, "R5");
    rd(8'h00, "R5");
    wr(8'h0C, 32'h0000_0000, "R5");

    wr(8'h20, 32'hDEAD_BEEF, "R6");
    rd(8'h20, "R6");

    wr(8'h10, 32'hFFFF_FFFF, "R7");
    wr(8'h14, 32'hFFFF_FFFF, "R7");
    wr(8'h18, 32'hFFFF_FFFF, "R7");
    rd(8'h10, "R7"); rd(8'h14, "R7"); rd(8'h18, "R7");
    rd(8'h00, "R7");

    wr(8'h00, 32'hFFFF_FFFF, "R8");
    rd(8'h00, "R8");
    rd(8'h08, "R8"); rd(8'h0C, "R8"); rd(8'h24, "R8");
    rd(8'h05, "R8");
    wr(8'h06, 32'h1234_5678, "R8");   // misaligned direction write
    rd(8'h04, "R8");
    wr(8'h40, 32'h0, "R8");
    wr(8'h22, 32'h0, "R8");
    rd(8'h20, "R8");

    rd(8'h24, "R9"); idle("R9"); rd(8'h04, "R9"); rd(8'h24, "R9"); idle("R9");

    for (int i = 0; i < 400; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      bit          v, w;
      case ($urandom_range(0, 9))
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        4: a = 8'h10; 5: a = 8'h18; 6: a = 8'h20; 7: a = 8'h03;
        8: a = 8'h44; default: a = 8'h08;
      endcase
      d = $urandom();
      if ($urandom_range(0, 1) == 1) d = d & 32'h0000_F0F0;
      v = ($urandom_range(0, 4) != 0);
      w = ($urandom_range(0, 1) == 1);
      step(v, w, a, d, "R9");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

endmodule